// File: doc/BRIEF.md
# Wired Remote Keycode Decoder

This block listens to the single data wire of a wired remote control and turns each received character into a key event. It recovers asynchronous characters (one low start bit, eight data bits with the least significant bit first, one high stop bit) at 9600 baud. It compares each character against the six codes the remote sends, and reports a matching key on a one-hot identifier together with a one-cycle valid strobe.

Holding a button makes the remote send the same code over and over. The decoder measures the time since the previous reported key. It marks the event as a repeat when the same code comes back within a set window, which defaults to 0.5 s. A later arrival is reported as a fresh press, and this includes gaps between 0.5 s and 1 s. Characters whose stop bit is low raise a one-cycle framing-error flag. Characters that match no key are dropped silently.

The clock frequency, the baud rate and the repeat window are parameters. The baud divider and the window length in cycles are derived from them.

Top module: `remote_key_decoder`

## Requirements
- R1: The line is sampled with a tick at 16 times the baud rate, where the tick divider is CLK_HZ/(16*BAUD). A character is one low start bit, eight data bits with the least significant bit first, and one high stop bit.
- R2: A low pulse on the idle line that has returned high by the middle of the start bit produces neither a key strobe nor a framing error.
- R3: Key identifier bit positions map from received bytes as follows: bit 0 = 0xC1 (play), bit 1 = 0xC2 (stop), bit 2 = 0xC4 (minus), bit 3 = 0xC8 (plus), bit 4 = 0xD0 (volume up), bit 5 = 0xE0 (volume down). Exactly one bit is set with each strobe.
- R4: key_valid is high for exactly one clock cycle for each accepted character.
- R5: key_id and key_repeat hold their value from one key_valid strobe until the next one.
- R6: A code equal to the previously reported code that arrives fewer than CLK_HZ/1000*REPEAT_MS cycles after the previous strobe is reported with key_repeat = 1.
- R7: A code equal to the previous one that arrives at or after that window, including gaps between 0.5 s and 1 s with the default parameters, is reported with key_repeat = 0.
- R8: A code that differs from the previously reported code is reported with key_repeat = 0.
- R9: A character whose stop bit is sampled low raises frame_error for one cycle and produces no key strobe. It does not change the repeat-tracking state.
- R10: A byte outside the table produces no strobe and no framing error. It clears the repeat-tracking state, so the next known code is reported with key_repeat = 0.
- R11: After a synchronous active-low reset, key_valid, key_id, key_repeat and frame_error are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Raw serial line from the remote, idle high |
| key_valid | output | 1 | One-cycle strobe for an accepted key |
| key_id | output | 6 | One-hot key identifier |
| key_repeat | output | 1 | Key is an auto-repeat of a held button |
| frame_error | output | 1 | One-cycle flag for a low stop bit |

## Verification
The embedded assertions check the following on every cycle:
- the strobe lasts one cycle;
- the identifier is one-hot whenever the strobe is high;
- the outputs hold steady between strobes;
- a framing error never coincides with a key;
- the repeat timer stays within its window.

Only the bench scenarios can show the remaining behaviour. These are the exact mapping of bytes to keys, the repeat and fresh-press decisions on both sides of the window, the rejection of short start glitches, and how the tracking state reacts to unknown bytes and bad stop bits.

// File: rtl/rk_pkg.sv
// Shared constants and types for the remote key decoder.
package rk_pkg;
    localparam int KEY_COUNT = 6;
    localparam int OVERSAMPLE = 16;

    typedef logic [KEY_COUNT-1:0] key_vec_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rk_baud_tick.sv
// Free-running oversampling tick generator.
// Emits a one-cycle tick every DIV clocks, which is 16 ticks per bit.
// Assumes CLK_HZ is at least 16*BAUD so that DIV >= 1.
module rk_baud_tick #(
    parameter int CLK_HZ = 250_000_000,
    parameter int BAUD   = 9600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    import rk_pkg::*;

    localparam int DIV_RAW = CLK_HZ / (BAUD * OVERSAMPLE);
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int DIV_W   = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] div_cnt;

    // Count clocks and wrap at DIV-1, raising tick on the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == DIV_W'(DIV - 1)) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/rk_uart_rx.sv
// 8N1 character receiver with mid-bit sampling on a 16x tick.
// A start is armed only on a high-to-low transition seen on ticks, and it is
// confirmed low at its midpoint. The stop bit decides between byte_strobe and
// ferr_strobe. Assumes rx_line is asynchronous; it is synchronised here.
module rk_uart_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_line,
    output logic [7:0] rx_byte,
    output logic       byte_strobe,
    output logic       ferr_strobe
);
    import rk_pkg::*;

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

    logic [1:0]       sync_q;
    logic             line_s;
    logic             prev_s;
    rx_state_t        state;
    logic [CNT_W-1:0] os_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shift_q;

    assign line_s = sync_q[1];

    // Two-flop synchroniser, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    // Line level seen on the previous tick, for start-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_s <= 1'b1;
        else if (tick) prev_s <= line_s;
    end

    // Receive state machine: start check, data shift, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            os_cnt      <= '0;
            bit_idx     <= '0;
            shift_q     <= '0;
            rx_byte     <= '0;
            byte_strobe <= 1'b0;
            ferr_strobe <= 1'b0;
        end else begin
            byte_strobe <= 1'b0;
            ferr_strobe <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (prev_s && !line_s) begin
                            state  <= RX_START;
                            os_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (os_cnt == MID_CNT) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            state   <= line_s ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (os_cnt == LAST_CNT) begin
                            os_cnt  <= '0;
                            shift_q <= {line_s, shift_q[7:1]};
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == 3'd7) state <= RX_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (os_cnt == LAST_CNT) begin
                            os_cnt <= '0;
                            state  <= RX_IDLE;
                            if (line_s) begin
                                rx_byte     <= shift_q;
                                byte_strobe <= 1'b1;
                            end else begin
                                ferr_strobe <= 1'b1;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R9: a character ends either good or framed badly, never both.
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_strobe && ferr_strobe));

    // R1: a strobe can only follow a stop-bit sample on a tick.
    p_strobe_after_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_strobe || ferr_strobe) |-> $past(state == RX_STOP && tick));
endmodule

// File: rtl/rk_key_map.sv
// Fixed six-entry keycode table: byte in, one-hot key and hit flag out.
// Purely combinational; bit order is part of the block's interface.
module rk_key_map (
    input  logic             [7:0] code,
    output rk_pkg::key_vec_t       key_vec,
    output logic                   hit
);
    // Decode the byte into its one-hot key position.
    always_comb begin
        unique case (code)
            8'hC1:   key_vec = 6'b000001;
            8'hC2:   key_vec = 6'b000010;
            8'hC4:   key_vec = 6'b000100;
            8'hC8:   key_vec = 6'b001000;
            8'hD0:   key_vec = 6'b010000;
            8'hE0:   key_vec = 6'b100000;
            default: key_vec = 6'b000000;
        endcase
        hit = |key_vec;
    end
endmodule

// File: rtl/rk_repeat_class.sv
// Repeat/new-press classifier with registered key outputs.
// A saturating timer measures clocks since the last reported key. An equal
// code inside the window is a repeat. An unknown byte forgets the last code.
module rk_repeat_class #(
    parameter int REPEAT_CYCLES = 125_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_strobe,
    input  logic             hit,
    input  rk_pkg::key_vec_t key_vec,
    output logic             key_valid,
    output rk_pkg::key_vec_t key_id,
    output logic             key_repeat
);
    import rk_pkg::*;

    localparam int GAP_W = $clog2(REPEAT_CYCLES + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(REPEAT_CYCLES);

    logic [GAP_W-1:0] gap_cnt;
    key_vec_t         last_key;
    logic             have_last;
    logic             is_repeat;

    assign is_repeat = have_last && (key_vec == last_key) && (gap_cnt < GAP_MAX);

    // Saturating timer since the last reported key, restarted on each one.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gap_cnt <= GAP_MAX;
        else if (byte_strobe && hit)  gap_cnt <= '0;
        else if (gap_cnt != GAP_MAX)  gap_cnt <= gap_cnt + 1'b1;
    end

    // Tracking of the last reported code; unknown bytes forget it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_key  <= '0;
            have_last <= 1'b0;
        end else if (byte_strobe) begin
            last_key  <= key_vec;
            have_last <= hit;
        end
    end

    // Output register: the strobe pulses and id/repeat update together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_valid  <= 1'b0;
            key_id     <= '0;
            key_repeat <= 1'b0;
        end else begin
            key_valid <= byte_strobe && hit;
            if (byte_strobe && hit) begin
                key_id     <= key_vec;
                key_repeat <= is_repeat;
            end
        end
    end

    // R7: the gap timer never passes the window limit.
    p_gap_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GAP_MAX);

    // R6: a repeat is only reported when the timer was inside the window.
    p_repeat_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_repeat) |-> $past(gap_cnt < GAP_MAX));
endmodule

// File: rtl/remote_key_decoder.sv
// Top of the wired-remote keycode decoder.
// Chain: tick generator -> 8N1 receiver -> key table -> repeat classifier.
// The repeat window is REPEAT_MS milliseconds of CLK_HZ clocks.
module remote_key_decoder #(
    parameter int CLK_HZ    = 250_000_000,
    parameter int BAUD      = 9600,
    parameter int REPEAT_MS = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    output logic       key_valid,
    output logic [5:0] key_id,
    output logic       key_repeat,
    output logic       frame_error
);
    import rk_pkg::*;

    localparam int REPEAT_CYCLES = (CLK_HZ / 1000) * REPEAT_MS;

    logic     tick;
    logic [7:0] rx_byte;
    logic     byte_strobe;
    logic     ferr_strobe;
    key_vec_t key_vec;
    logic     hit;

    rk_baud_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rk_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
        .rx_byte(rx_byte), .byte_strobe(byte_strobe), .ferr_strobe(ferr_strobe)
    );

    rk_key_map u_map (
        .code(rx_byte), .key_vec(key_vec), .hit(hit)
    );

    rk_repeat_class #(.REPEAT_CYCLES(REPEAT_CYCLES)) u_class (
        .clk(clk), .rst_n(rst_n), .byte_strobe(byte_strobe), .hit(hit),
        .key_vec(key_vec), .key_valid(key_valid), .key_id(key_id),
        .key_repeat(key_repeat)
    );

    assign frame_error = ferr_strobe;

    // R4: the key strobe never lasts two cycles.
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R3: every strobe carries exactly one key bit.
    p_id_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $countones(key_id) == 1);

    // R5: identifier and repeat flag hold between strobes.
    p_id_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> ($stable(key_id) && $stable(key_repeat)));

    // R9: a framing error is never reported together with a key.
    p_ferr_no_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> !key_valid);
endmodule

// File: tb/remote_key_decoder_test.sv
`timescale 1ns/1ps
module remote_key_decoder_test;
    localparam int CLK_HZ    = 614_400;
    localparam int BAUD      = 9600;
    localparam int REPEAT_MS = 5;
    localparam int BIT_CYC   = (CLK_HZ / (BAUD * 16)) * 16;
    localparam int WINDOW    = (CLK_HZ / 1000) * REPEAT_MS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       key_valid;
    logic [5:0] key_id;
    logic       key_repeat;
    logic       frame_error;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    remote_key_decoder #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .REPEAT_MS(REPEAT_MS)) uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .key_valid(key_valid),
        .key_id(key_id), .key_repeat(key_repeat), .frame_error(frame_error)
    );

    // Observation state collected at negedge.
    longint cyc = 0;
    int strobes = 0;
    int ferrs = 0;
    longint last_strobe_cyc = 0;
    logic [5:0] seen_id = '0;
    logic seen_rep = 1'b0;
    logic prev_valid = 1'b0;
    logic [5:0] prev_id = '0;
    logic prev_rep = 1'b0;

    // Reference model of repeat tracking.
    logic [7:0] m_last = 8'h00;
    bit m_have = 1'b0;
    longint m_time = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] expect_key(input logic [7:0] b);
        case (b)
            8'hC1: return 6'b000001;
            8'hC2: return 6'b000010;
            8'hC4: return 6'b000100;
            8'hC8: return 6'b001000;
            8'hD0: return 6'b010000;
            8'hE0: return 6'b100000;
            default: return 6'b000000;
        endcase
    endfunction

    // Per-cycle monitor: records events and checks R4, R5, R9 invariants.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            check(!(prev_valid && key_valid), "R4", "strobe width", 2, 1);
            if (!key_valid)
                check(key_id == prev_id && key_repeat == prev_rep, "R5",
                      "hold between strobes", {key_id, key_repeat}, {prev_id, prev_rep});
            check(!(key_valid && frame_error), "R9", "ferr with key", 1, 0);
            if (key_valid) begin
                strobes <= strobes + 1;
                last_strobe_cyc <= cyc;
                seen_id <= key_id;
                seen_rep <= key_repeat;
            end
            if (frame_error) ferrs <= ferrs + 1;
        end
        prev_valid <= key_valid;
        prev_id <= key_id;
        prev_rep <= key_repeat;
    end

    task automatic hold_line(input logic v, input int n);
        @(posedge clk);
        #1 rx_line = v;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        hold_line(1'b0, BIT_CYC);
        for (int i = 0; i < 8; i++) hold_line(b[i], BIT_CYC);
        hold_line(stop_bit, BIT_CYC);
        hold_line(1'b1, 4);
    endtask

    // Send one character, then compare the outcome with the model.
    task automatic send_and_check(input logic [7:0] b, input logic stop_ok,
                                  input int idle, input string req);
        int s0, f0;
        logic [5:0] ek;
        bit erep;
        s0 = strobes;
        f0 = ferrs;
        ek = expect_key(b);
        send_frame(b, stop_ok);
        @(negedge clk);
        if (!stop_ok) begin
            check(strobes == s0, req, "no key on bad stop", strobes - s0, 0);
            check(ferrs == f0 + 1, req, "frame_error count", ferrs - f0, 1);
        end else if (ek == 6'b0) begin
            check(strobes == s0, req, "no key for unknown", strobes - s0, 0);
            check(ferrs == f0, req, "no ferr for unknown", ferrs - f0, 0);
            m_have = 1'b0;
        end else begin
            erep = m_have && (m_last == b) && ((last_strobe_cyc - m_time) < WINDOW);
            check(strobes == s0 + 1, req, "one strobe", strobes - s0, 1);
            check(seen_id == ek, req, "key_id", seen_id, ek);
            check(seen_rep == erep, req, "key_repeat", seen_rep, erep);
            m_have = 1'b1;
            m_last = b;
            m_time = last_strobe_cyc;
        end
        if (idle > 0) repeat (idle) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(key_valid == 0 && key_id == 0 && key_repeat == 0 && frame_error == 0,
              "R11", "reset outputs", {key_valid, key_id, key_repeat, frame_error}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (50) @(posedge clk);

        // R1, R3: every table entry decodes to its own bit.
        send_and_check(8'hC1, 1'b1, 3000, "R3");
        send_and_check(8'hC2, 1'b1, 3000, "R3");
        send_and_check(8'hC4, 1'b1, 3000, "R3");
        send_and_check(8'hC8, 1'b1, 3000, "R3");
        send_and_check(8'hD0, 1'b1, 3000, "R1");
        send_and_check(8'hE0, 1'b1, 3000, "R1");

        // R7: same code after the window is a fresh press.
        send_and_check(8'hE0, 1'b1, 1000, "R7");
        // R6: same code inside the window is a repeat.
        send_and_check(8'hE0, 1'b1, 1000, "R6");
        send_and_check(8'hE0, 1'b1, 1000, "R6");
        // R8: a different code inside the window is not a repeat.
        send_and_check(8'hC4, 1'b1, 200, "R8");

        // R10: an unknown byte clears tracking.
        send_and_check(8'h55, 1'b1, 200, "R10");
        send_and_check(8'hC4, 1'b1, 200, "R10");

        // R9: a bad stop bit leaves tracking untouched.
        send_and_check(8'hC4, 1'b0, 200, "R9");
        send_and_check(8'hC4, 1'b1, 3000, "R9");

        // R2: a short glitch is not a start bit.
        begin
            int s0, f0;
            s0 = strobes;
            f0 = ferrs;
            hold_line(1'b0, BIT_CYC / 4);
            hold_line(1'b1, 12 * BIT_CYC);
            @(negedge clk);
            check(strobes == s0 && ferrs == f0, "R2", "glitch ignored",
                  (strobes - s0) + (ferrs - f0), 0);
        end
        send_and_check(8'hC8, 1'b1, 500, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule